// File: doc/BRIEF.md
# Indirect Extended Register Window

This block is one 8-bit host register with two meanings. In pointer mode it holds a 5-bit selector into a bank of extended registers, a freeze control bit and an enable bit. When the extended operating mode is active and the host writes the enable bit as 1, the same register turns into a data window. Host reads and writes then go straight through to the selected extended register, and the block drives the bank's strobes and address.

Once the register is a data window, only a write to a different index register brings it back to pointer mode. When the extended operating mode is off, the register is a plain storage byte and never touches the bank. The bank decodes selectors 0 to 17 and 25. Any other selector reads as zero and drops writes.

Top module: `xwin_port`

## Requirements
- R1: After reset the pointer byte is 0x00, the block is in pointer mode, `host_rdata_o` is 0x00, `freeze_o` is 0 and both bank strobes are low.
- R2: In pointer mode a host write stores the byte, and `host_rdata_o` shows it from the next cycle. The layout is: bits 7:4 are selector bits 3:0, bit 3 is the enable, bit 2 is selector bit 4, bit 1 is reserved and always reads 0, and bit 0 is the freeze control.
- R3: When `ext_mode_en_i` is 1 and the stored enable bit is 1, the block is in data mode. `xb_addr_o` always equals {bit 2, bits 7:4} of the pointer byte.
- R4: In data mode with a supported selector, a host write raises `xb_wr_o` in the same cycle and puts the host byte on `xb_wdata_o`. The pointer byte stays unchanged.
- R5: In data mode with a supported selector, `host_rdata_o` equals `xb_rdata_i`, and `xb_rd_o` rises in the same cycle as a host read.
- R6: A pulse on `index_wr_i` clears the stored enable bit, and this wins over a host write in the same cycle. From the next cycle the block is in pointer mode, with the selector and freeze bits kept.
- R7: Selectors 18 to 24 and 26 to 31 are unsupported. In data mode they read as 0x00, and neither bank strobe rises for them.
- R8: When `ext_mode_en_i` is 0 the byte is a plain register: writes store it (reserved bit masked), reads return it with the enable bit included, and no bank strobe rises. If the extended mode is raised while the stored enable bit is 1, data mode starts at once.
- R9: `freeze_o` follows bit 0 of the pointer byte. Data-mode accesses do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_en_i | input | 1 | Extended operating mode active |
| host_wr_i | input | 1 | Host write strobe for this register |
| host_rd_i | input | 1 | Host read strobe for this register |
| host_wdata_i | input | 8 | Host write data |
| index_wr_i | input | 1 | A different index register was written |
| host_rdata_o | output | 8 | Read value of this register |
| freeze_o | output | 1 | Freeze control bit |
| xb_addr_o | output | 5 | Extended bank selector |
| xb_wr_o | output | 1 | Extended bank write strobe |
| xb_rd_o | output | 1 | Extended bank read strobe |
| xb_wdata_o | output | 8 | Extended bank write data |
| xb_rdata_i | input | 8 | Extended bank read data |

## Verification
The bench writes pointer bytes that select all 32 selectors, then writes and reads each one through the data window. This separates the supported selectors from the unsupported ones and checks that the bit-4 selector is placed correctly. Writes with the reserved bit set show that this bit is masked. Writes with the extended mode off show plain-register behaviour. An index write issued together with a data write shows which of the two wins. Dropping and raising the extended mode while the enable bit stays stored shows that the mode gates the data window straight away.

// File: rtl/xwin_pkg.sv
package xwin_pkg;
  localparam int XW_DW      = 8;
  localparam int XW_AW      = 5;
  localparam int XW_EN_BIT  = 3;
  localparam int XW_HI_BIT  = 2;
  localparam int XW_RES_BIT = 1;
  localparam int XW_FRZ_BIT = 0;
  localparam int XW_LO_MSB  = 7;
  localparam int XW_LO_LSB  = 4;
  localparam logic [XW_DW-1:0] XW_RES_MASK = XW_DW'(1) << XW_RES_BIT;

  typedef logic [XW_DW-1:0] xw_byte_t;
  typedef logic [XW_AW-1:0] xw_addr_t;

  function automatic xw_addr_t xw_addr_of(input xw_byte_t p);
    return {p[XW_HI_BIT], p[XW_LO_MSB:XW_LO_LSB]};
  endfunction
endpackage

// File: rtl/xwin_addr_chk.sv
module xwin_addr_chk
  import xwin_pkg::*;
#(
  parameter int LOW_LAST   = 17,
  parameter int EXTRA_ADDR = 25
) (
  input  xw_addr_t addr_i,
  output logic     ok_o
);
  localparam xw_addr_t LOW_A   = XW_AW'(LOW_LAST);
  localparam xw_addr_t EXTRA_A = XW_AW'(EXTRA_ADDR);

  logic in_low;
  logic is_extra;

  assign in_low = (addr_i <= LOW_A);

  generate
    if (EXTRA_ADDR > LOW_LAST) begin : g_extra
      assign is_extra = (addr_i == EXTRA_A);
    end else begin : g_no_extra
      assign is_extra = 1'b0;
    end
  endgenerate

  assign ok_o = in_low | is_extra;
endmodule

// File: rtl/xwin_ptr_reg.sv
module xwin_ptr_reg
  import xwin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic     clr_en_i,
  input  xw_byte_t wdata_i,
  output xw_byte_t ptr_q_o
);
  xw_byte_t ptr_q;
  xw_byte_t ptr_d;
  logic     ptr_ce;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = wdata_i & ~XW_RES_MASK;
    end
    if (clr_en_i) begin
      ptr_d[XW_EN_BIT] = 1'b0;
    end
  end

  assign ptr_ce = load_i | clr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_q_o = ptr_q;
endmodule

// File: rtl/xwin_port_ctl.sv
module xwin_port_ctl
  import xwin_pkg::*;
(
  input  logic     ext_mode_i,
  input  xw_byte_t ptr_i,
  input  logic     addr_ok_i,
  input  logic     host_wr_i,
  input  logic     host_rd_i,
  input  xw_byte_t xb_rdata_i,
  output logic     data_mode_o,
  output logic     xb_wr_o,
  output logic     xb_rd_o,
  output xw_byte_t rdata_o
);
  logic live;

  assign data_mode_o = ext_mode_i & ptr_i[XW_EN_BIT];
  assign live        = data_mode_o & addr_ok_i;
  assign xb_wr_o     = live & host_wr_i;
  assign xb_rd_o     = live & host_rd_i;

  always_comb begin
    if (!data_mode_o) begin
      rdata_o = ptr_i;
    end else if (addr_ok_i) begin
      rdata_o = xb_rdata_i;
    end else begin
      rdata_o = '0;
    end
  end
endmodule

// File: rtl/xwin_port.sv
module xwin_port
  import xwin_pkg::*;
#(
  parameter int LOW_LAST   = 17,
  parameter int EXTRA_ADDR = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_mode_en_i,
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic [7:0] host_wdata_i,
  input  logic       index_wr_i,
  output logic [7:0] host_rdata_o,
  output logic       freeze_o,
  output logic [4:0] xb_addr_o,
  output logic       xb_wr_o,
  output logic       xb_rd_o,
  output logic [7:0] xb_wdata_o,
  input  logic [7:0] xb_rdata_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  xw_byte_t ptr_q;
  xw_addr_t sel;
  logic     sel_ok;
  logic     data_mode;

  xwin_ptr_reg i_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (host_wr_i & ~data_mode),
    .clr_en_i (index_wr_i),
    .wdata_i  (host_wdata_i),
    .ptr_q_o  (ptr_q)
  );

  assign sel = xw_addr_of(ptr_q);

  xwin_addr_chk #(
    .LOW_LAST   (LOW_LAST),
    .EXTRA_ADDR (EXTRA_ADDR)
  ) i_chk_addr (
    .addr_i (sel),
    .ok_o   (sel_ok)
  );

  xwin_port_ctl i_ctl (
    .ext_mode_i  (ext_mode_en_i),
    .ptr_i       (ptr_q),
    .addr_ok_i   (sel_ok),
    .host_wr_i   (host_wr_i),
    .host_rd_i   (host_rd_i),
    .xb_rdata_i  (xb_rdata_i),
    .data_mode_o (data_mode),
    .xb_wr_o     (xb_wr_o),
    .xb_rd_o     (xb_rd_o),
    .rdata_o     (host_rdata_o)
  );

  assign xb_addr_o  = sel;
  assign xb_wdata_o = host_wdata_i;
  assign freeze_o   = ptr_q[XW_FRZ_BIT];
endmodule

// File: rtl/xwin_port_chk.sv
module xwin_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_mode_en_i,
  input logic       host_wr_i,
  input logic       host_rd_i,
  input logic       index_wr_i,
  input logic [7:0] host_rdata_o,
  input logic       freeze_o,
  input logic [4:0] xb_addr_o,
  input logic       xb_wr_o,
  input logic       xb_rd_o
);
  logic legal;
  assign legal = (xb_addr_o <= 5'd17) || (xb_addr_o == 5'd25);

  a_r4_wr_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
    xb_wr_o |-> host_wr_i);

  a_r5_rd_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
    xb_rd_o |-> host_rd_i);

  a_r7_no_strobe_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_wr_o || xb_rd_o) |-> legal);

  a_r8_plain_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode_en_i |-> (!xb_wr_o && !xb_rd_o));

  a_r6_index_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    index_wr_i |=> (!xb_wr_o && !xb_rd_o));

  a_r4_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xb_wr_o |=> $stable(xb_addr_o));

  a_r9_freeze_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xb_wr_o |=> $stable(freeze_o));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !xb_rd_o) |-> !host_rdata_o[1]);
endmodule

bind xwin_port xwin_port_chk i_port_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_mode_en_i (ext_mode_en_i),
  .host_wr_i     (host_wr_i),
  .host_rd_i     (host_rd_i),
  .index_wr_i    (index_wr_i),
  .host_rdata_o  (host_rdata_o),
  .freeze_o      (freeze_o),
  .xb_addr_o     (xb_addr_o),
  .xb_wr_o       (xb_wr_o),
  .xb_rd_o       (xb_rd_o)
);

// File: tb/test_xwin_port.sv
`timescale 1ns/1ps
module test_xwin_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mode;
  logic       hwr, hrd, idx;
  logic [7:0] hwd;
  logic [7:0] rdata;
  logic       frz;
  logic [4:0] xaddr;
  logic       xwr, xrd;
  logic [7:0] xwd;
  logic [7:0] xrdata;

  always #2 clk = ~clk;

  // behavioural reference state
  logic [7:0] m_ptr;
  logic [7:0] bank [32];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic logic [4:0] m_sel();
    return {m_ptr[2], m_ptr[7:4]};
  endfunction

  function automatic bit m_ok(input logic [4:0] a);
    return (int'(a) <= 17) || (int'(a) == 25);
  endfunction

  assign xrdata = bank[{m_ptr[2], m_ptr[7:4]}];

  xwin_port i_xwin_port (
    .clk (clk), .rst_n (rst_n), .ext_mode_en_i (ext_mode),
    .host_wr_i (hwr), .host_rd_i (hrd), .host_wdata_i (hwd),
    .index_wr_i (idx), .host_rdata_o (rdata), .freeze_o (frz),
    .xb_addr_o (xaddr), .xb_wr_o (xwr), .xb_rd_o (xrd),
    .xb_wdata_o (xwd), .xb_rdata_i (xrdata)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input bit e, input bit w, input bit r,
                      input bit ix, input logic [7:0] d);
    logic [4:0] a;
    bit dm, ok;
    logic [7:0] exp_rd, nxt;
    @(negedge clk);
    ext_mode = e; hwr = w; hrd = r; idx = ix; hwd = d;
    #1;
    a  = m_sel();
    dm = e && m_ptr[3];
    ok = m_ok(a);
    exp_rd = !dm ? m_ptr : (ok ? bank[a] : 8'h00);
    vectors++;
    cmp(req, "rdata", int'(rdata), int'(exp_rd));
    cmp(req, "xb_wr", int'(xwr), int'(w && dm && ok));
    cmp(req, "xb_rd", int'(xrd), int'(r && dm && ok));
    cmp(req, "xb_addr", int'(xaddr), int'(a));
    cmp(req, "freeze", int'(frz), int'(m_ptr[0]));
    if (w && dm && ok) cmp(req, "xb_wdata", int'(xwd), int'(d));
    nxt = m_ptr;
    if (w && !dm) nxt = d & 8'hFD;
    if (ix) nxt[3] = 1'b0;
    @(posedge clk);
    if (rst_n) begin
      if (w && dm && ok) bank[a] = d;
      m_ptr = nxt;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) bank[i] = 8'(i * 7 + 3);
    m_ptr = 8'h00;
    rst_n = 1'b0; ext_mode = 1'b0; hwr = 0; hrd = 0; idx = 0; hwd = 8'h00;
    // R1 reset state, during and after reset
    step("R1", 1, 0, 1, 0, 8'h00);
    step("R1", 1, 0, 0, 0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R1", 1, 0, 1, 0, 8'h00);

    // R2 pointer write with reserved bit set, R9 freeze follows bit 0
    step("R2", 1, 1, 0, 0, 8'h53);
    step("R2", 1, 0, 1, 0, 8'h00);
    step("R9", 1, 1, 0, 0, 8'h50);
    // R3 enter data mode at selector 5, with freeze set
    step("R3", 1, 1, 0, 0, 8'h59);
    step("R4", 1, 1, 0, 0, 8'hA5);
    step("R5", 1, 0, 1, 0, 8'h00);
    step("R9", 1, 1, 1, 0, 8'h3C);
    // R6 back to pointer mode, selector and freeze kept
    step("R6", 1, 0, 0, 1, 8'h00);
    step("R6", 1, 0, 1, 0, 8'h00);
    // selector 17 and 25 need bit 4
    step("R3", 1, 1, 0, 0, 8'h1C);
    step("R4", 1, 1, 0, 0, 8'h71);
    step("R5", 1, 0, 1, 0, 8'h00);
    step("R6", 1, 0, 0, 1, 8'h00);
    step("R3", 1, 1, 0, 0, 8'h9C);
    step("R4", 1, 1, 0, 0, 8'h99);
    step("R5", 1, 0, 1, 0, 8'h00);
    // R6 index write wins over a same-cycle data write
    step("R6", 1, 1, 0, 1, 8'h42);
    step("R6", 1, 0, 1, 0, 8'h00);
    // R7 unsupported selectors 18 and 31
    step("R7", 1, 1, 0, 0, 8'h2C);
    step("R7", 1, 1, 1, 0, 8'hEE);
    step("R6", 1, 0, 0, 1, 8'h00);
    step("R7", 1, 1, 0, 0, 8'hFC);
    step("R7", 1, 1, 1, 0, 8'h11);
    step("R6", 1, 0, 0, 1, 8'h00);
    // R8 plain register with extended mode off
    step("R8", 0, 1, 0, 0, 8'h3B);
    step("R8", 0, 1, 1, 0, 8'h77);
    step("R8", 0, 0, 1, 0, 8'h00);
    step("R8", 1, 0, 1, 0, 8'h00);
    step("R8", 1, 1, 0, 0, 8'hC4);
    step("R8", 0, 1, 1, 0, 8'h00);
    step("R8", 1, 0, 1, 0, 8'h00);
    step("R6", 1, 0, 0, 1, 8'h00);
    // sweep all selectors through the window
    for (int s = 0; s < 32; s++) begin
      logic [7:0] p;
      p = {s[3:0], 1'b1, s[4], 1'b0, s[0]};
      step("R3", 1, 1, 0, 0, p);
      step("R7", 1, 1, 0, 0, 8'(s * 13 + 1));
      step("R5", 1, 0, 1, 0, 8'h00);
      step("R6", 1, 0, 1, 1, 8'h00);
      step("R2", 1, 0, 1, 0, 8'h00);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule